// File: doc/BRIEF.md
# Machine State Register Update Unit

This unit owns a 64-bit machine state register. Bits are named in big-endian order: bit 0 is the most significant, so named bit n sits at vector index 63-n. Each cycle the unit picks one action and applies it to the register at the rising clock edge. It can leave the register alone. It can apply a trap entry. It can apply one of two move-to-state instructions: a narrow form that touches only the low word, or a wide form that can also reach the high word.

Both move forms take a one-bit scope flag and a 64-bit source operand. With the flag clear, whole groups of fields are written. Three fields are also forced on whenever the source's problem-state bit (bit 49) is set. The wide form additionally guards a 3-bit field against one transition that is not allowed. With the flag set, only two bits are written. On trap entry, the unit copies the pre-trap value into a save/restore output. It then rewrites the relocation, UND and endian bits in the register.

The action selector is a four-way enumeration with these members:
- ACT_HOLD: no operation, or the reserved select code.
- ACT_TRAP: the trap strobe is high, whatever the select says.
- ACT_MV32: select code 01.
- ACT_MV64: select code 10.

The register returns to ACT_HOLD behaviour in any cycle without a request.

Top module: `mach_state_upd`

## Requirements
- R1: On synchronous reset, `state_q` takes parameter RESET_VAL, `state_vld` goes low and `saved_state` goes to zero. These values are visible after the reset edge.
- R2: With `op_sel`=01 (narrow form) and `lflag`=0, register bits 32:47, 49:50, 52:57 and 60:62 take the matching `rs_val` bits. Bits 0:31 and all other bits not named in R3 keep their values.
- R3: With `lflag`=0 in either form, bit 48 becomes rs[48]|rs[49], bit 58 becomes rs[58]|rs[49], and bit 59 becomes rs[59]|rs[49].
- R4: With `lflag`=1 in either form, only bits 48 and 62 are written, from the matching `rs_val` bits. Every other bit is kept.
- R5: With `op_sel`=10 (wide form) and `lflag`=0, bits 0:2 and 4:28 are also copied from `rs_val`, on top of the R2 ranges.
- R6: In the wide form with `lflag`=0, bits 29:31 take rs[29:31] unless the current value is 3'b010 and rs[29:31] is 3'b000. In that case the field keeps 3'b010. Bit 29 is the field's most significant bit.
- R7: Bit 3 is never changed by either move form.
- R8: When `trap_req` is high, the pre-trap register value appears on `saved_state` after the edge. In the new register value, bit IR_POS (default 58) and bit UND_POS (default 5) are cleared, bit LE_POS (default 63) is set, and all other bits are kept.
- R9: When `trap_req` and a move select occur in the same cycle, only the trap is applied.
- R10: `state_vld` is high in the cycle after a move form was applied, and low after any other action.
- R11: `op_sel` values 00 and 11 leave `state_q` and `saved_state` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 2 | 00 none, 01 narrow move, 10 wide move, 11 reserved (none) |
| lflag | input | 1 | Scope flag of the move instruction |
| rs_val | input | 64 | Source operand, big-endian bit numbering |
| trap_req | input | 1 | Trap-entry strobe, wins over a move |
| state_q | output | 64 | Current machine state register |
| state_vld | output | 1 | High after a move was applied |
| saved_state | output | 64 | Save/restore copy of the pre-trap state |

## Verification
The bench builds the unit with a RESET_VAL that has bit 3 and bits 29:31=010 set, and keeps the default trap bit positions. This means the untouched bit 3 and the guarded field start in states where a wrong write shows up at once. A full 8x8 sweep of current and requested 29:31 values covers the forbidden transition and its neighbours. A long random run over every select code, scope flag and trap combination is checked against an arithmetic bit-level model, so that priority and hold cases are exercised next to the field masks.

// File: rtl/mach_state_pkg.sv
package mach_state_pkg;

    localparam int unsigned XLEN = 64;

    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_MV32 = 2'b01,
        SEL_MV64 = 2'b10,
        SEL_RSVD = 2'b11
    } sel_e;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_TRAP,
        ACT_MV32,
        ACT_MV64
    } act_e;

    // big-endian bit number to vector index
    function automatic int unsigned be_idx(input int unsigned n);
        return XLEN - 1 - n;
    endfunction

    // plain copy mask for a move form; forced and guarded bits excluded
    function automatic logic [XLEN-1:0] move_mask(input int unsigned wide,
                                                  input int unsigned lsel);
        logic [XLEN-1:0] m;
        m = '0;
        for (int unsigned n = 0; n < XLEN; n++) begin
            if (lsel != 0) begin
                if (n == 48 || n == 62) m[be_idx(n)] = 1'b1;
            end else begin
                if ((n >= 32 && n <= 47) || n == 49 || n == 50 ||
                    (n >= 52 && n <= 57) || (n >= 60 && n <= 62))
                    m[be_idx(n)] = 1'b1;
                if (wide != 0 && (n <= 2 || (n >= 4 && n <= 28)))
                    m[be_idx(n)] = 1'b1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/mst_action_sel.sv
module mst_action_sel
    import mach_state_pkg::*;
(
    input  logic [1:0] op_sel,
    input  logic       trap_req,
    output act_e       act
);
    sel_e sel;
    assign sel = sel_e'(op_sel);

    always_comb begin
        act = ACT_HOLD;
        if (trap_req) begin
            act = ACT_TRAP;
        end else begin
            unique case (sel)
                SEL_NONE: act = ACT_HOLD;
                SEL_MV32: act = ACT_MV32;
                SEL_MV64: act = ACT_MV64;
                SEL_RSVD: act = ACT_HOLD;
            endcase
        end
    end
endmodule

// File: rtl/mst_move_merge.sv
module mst_move_merge
    import mach_state_pkg::*;
#(
    parameter int unsigned WIDE = 0
) (
    input  logic [XLEN-1:0] cur,
    input  logic [XLEN-1:0] rs,
    input  logic            lflag,
    output logic [XLEN-1:0] res
);
    localparam logic [XLEN-1:0] MSK_FULL = move_mask(WIDE, 0);
    localparam logic [XLEN-1:0] MSK_SCOP = move_mask(WIDE, 1);
    localparam int unsigned     PR_I     = be_idx(49);
    localparam int unsigned     GRD_LO   = be_idx(31);
    localparam int unsigned     GRD_HI   = be_idx(29);

    logic pr;
    assign pr = rs[PR_I];

    always_comb begin
        if (lflag) begin
            res = (cur & ~MSK_SCOP) | (rs & MSK_SCOP);
        end else begin
            res = (cur & ~MSK_FULL) | (rs & MSK_FULL);
            res[be_idx(48)] = rs[be_idx(48)] | pr;
            res[be_idx(58)] = rs[be_idx(58)] | pr;
            res[be_idx(59)] = rs[be_idx(59)] | pr;
            if (WIDE != 0) begin
                if ((cur[GRD_HI:GRD_LO] != 3'b010) ||
                    (rs[GRD_HI:GRD_LO] != 3'b000))
                    res[GRD_HI:GRD_LO] = rs[GRD_HI:GRD_LO];
            end
        end
    end
endmodule

// File: rtl/mst_trap_merge.sv
module mst_trap_merge
    import mach_state_pkg::*;
#(
    parameter int unsigned IR_POS  = 58,
    parameter int unsigned UND_POS = 5,
    parameter int unsigned LE_POS  = 63
) (
    input  logic [XLEN-1:0] cur,
    output logic [XLEN-1:0] res
);
    always_comb begin
        res = cur;
        res[be_idx(IR_POS)]  = 1'b0;
        res[be_idx(UND_POS)] = 1'b0;
        res[be_idx(LE_POS)]  = 1'b1;
    end
endmodule

// File: rtl/mach_state_upd.sv
module mach_state_upd
    import mach_state_pkg::*;
#(
    parameter logic [63:0] RESET_VAL = 64'h0,
    parameter int unsigned IR_POS    = 58,
    parameter int unsigned UND_POS   = 5,
    parameter int unsigned LE_POS    = 63
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  op_sel,
    input  logic        lflag,
    input  logic [63:0] rs_val,
    input  logic        trap_req,
    output logic [63:0] state_q,
    output logic        state_vld,
    output logic [63:0] saved_state
);
    localparam int unsigned NFORM = 2;

    act_e                       act;
    logic [XLEN-1:0]            state_r, state_n;
    logic [XLEN-1:0]            save_r, save_n;
    logic                       vld_r, vld_n;
    logic [NFORM-1:0][XLEN-1:0] mv_res;
    logic [XLEN-1:0]            trap_res;

    mst_action_sel u_sel (
        .op_sel   (op_sel),
        .trap_req (trap_req),
        .act      (act)
    );

    for (genvar g = 0; g < NFORM; g++) begin : g_form
        mst_move_merge #(.WIDE(g)) u_mv (
            .cur   (state_r),
            .rs    (rs_val),
            .lflag (lflag),
            .res   (mv_res[g])
        );
    end

    mst_trap_merge #(
        .IR_POS  (IR_POS),
        .UND_POS (UND_POS),
        .LE_POS  (LE_POS)
    ) u_trap (
        .cur (state_r),
        .res (trap_res)
    );

    always_comb begin
        state_n = state_r;
        save_n  = save_r;
        vld_n   = 1'b0;
        unique case (act)
            ACT_HOLD: ;
            ACT_TRAP: begin
                state_n = trap_res;
                save_n  = state_r;
            end
            ACT_MV32: begin
                state_n = mv_res[0];
                vld_n   = 1'b1;
            end
            ACT_MV64: begin
                state_n = mv_res[1];
                vld_n   = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_r <= RESET_VAL;
            save_r  <= '0;
            vld_r   <= 1'b0;
        end else begin
            state_r <= state_n;
            save_r  <= save_n;
            vld_r   <= vld_n;
        end
    end

    always_comb begin
        state_q     = state_r;
        saved_state = save_r;
        state_vld   = vld_r;
    end
endmodule

// File: rtl/mst_checker.sv
module mst_checker #(
    parameter int unsigned IR_POS  = 58,
    parameter int unsigned UND_POS = 5,
    parameter int unsigned LE_POS  = 63
) (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  op_sel,
    input logic        lflag,
    input logic [63:0] rs_val,
    input logic        trap_req,
    input logic [63:0] state_q,
    input logic        state_vld,
    input logic [63:0] saved_state
);
    localparam logic [63:0] SCOPE_KEEP = ~((64'b1 << 15) | (64'b1 << 1));

    logic mv;
    assign mv = !trap_req && (op_sel == 2'b01 || op_sel == 2'b10);

    // R8
    trap_save_chk: assert property (@(posedge clk) disable iff (rst)
        trap_req |=> saved_state == $past(state_q));

    // R8
    trap_bits_chk: assert property (@(posedge clk) disable iff (rst)
        trap_req |=> (!state_q[63-IR_POS] && !state_q[63-UND_POS] && state_q[63-LE_POS]));

    // R7
    bit3_keep_chk: assert property (@(posedge clk) disable iff (rst)
        mv |=> state_q[60] == $past(state_q[60]));

    // R10
    vld_set_chk: assert property (@(posedge clk) disable iff (rst)
        mv |=> state_vld);

    // R10
    vld_clr_chk: assert property (@(posedge clk) disable iff (rst)
        !mv |=> !state_vld);

    // R4
    scope_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (mv && lflag) |=> ((state_q ^ $past(state_q)) & SCOPE_KEEP) == 64'h0);

    // R6
    guard_field_chk: assert property (@(posedge clk) disable iff (rst)
        (mv && op_sel == 2'b10 && !lflag && state_q[34:32] == 3'b010 &&
         rs_val[34:32] == 3'b000) |=> state_q[34:32] == 3'b010);

    // R3
    pr_force_chk: assert property (@(posedge clk) disable iff (rst)
        (mv && !lflag && rs_val[14]) |=> (state_q[15] && state_q[5] && state_q[4]));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!trap_req && (op_sel == 2'b00 || op_sel == 2'b11)) |=>
        ($stable(state_q) && $stable(saved_state)));
endmodule

bind mach_state_upd mst_checker #(
    .IR_POS  (IR_POS),
    .UND_POS (UND_POS),
    .LE_POS  (LE_POS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .op_sel      (op_sel),
    .lflag       (lflag),
    .rs_val      (rs_val),
    .trap_req    (trap_req),
    .state_q     (state_q),
    .state_vld   (state_vld),
    .saved_state (saved_state)
);

// File: tb/sim_mach_state_upd.sv
module sim_mach_state_upd;
    localparam logic [63:0] RST_V = 64'h1000_0002_0000_0000;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  op_sel;
    logic        lflag;
    logic [63:0] rs_val;
    logic        trap_req;
    logic [63:0] state_q;
    logic        state_vld;
    logic [63:0] saved_state;

    int checks = 0;
    int fails  = 0;
    logic [63:0] m_state, m_save;
    logic        m_vld;

    always #10 clk = ~clk;

    mach_state_upd #(.RESET_VAL(RST_V)) u0 (
        .clk(clk), .rst(rst), .op_sel(op_sel), .lflag(lflag), .rs_val(rs_val),
        .trap_req(trap_req), .state_q(state_q), .state_vld(state_vld),
        .saved_state(saved_state)
    );

    function automatic logic rsb(input logic [63:0] v, input int n);
        return v[63-n];
    endfunction

    // arithmetic reference: each big-endian bit position decided on its own
    function automatic logic [63:0] model(input logic [63:0] cur, input logic [1:0] op,
                                          input logic l, input logic [63:0] rs,
                                          input logic trap);
        logic [63:0] r;
        logic        wide;
        r = cur;
        wide = (op == 2'b10);
        if (trap) begin
            r[63-58] = 1'b0; r[63-5] = 1'b0; r[63-63] = 1'b1;
        end else if (op == 2'b01 || op == 2'b10) begin
            for (int n = 0; n < 64; n++) begin
                if (l) begin
                    if (n == 48 || n == 62) r[63-n] = rsb(rs, n);
                end else if (n == 48 || n == 58 || n == 59) begin
                    r[63-n] = rsb(rs, n) | rsb(rs, 49);
                end else if ((n >= 32 && n <= 47) || n == 49 || n == 50 ||
                             (n >= 52 && n <= 57) || (n >= 60 && n <= 62)) begin
                    r[63-n] = rsb(rs, n);
                end else if (wide && (n <= 2 || (n >= 4 && n <= 28))) begin
                    r[63-n] = rsb(rs, n);
                end
            end
            if (wide && !l) begin
                if (!({rsb(cur,29), rsb(cur,30), rsb(cur,31)} == 3'b010 &&
                      {rsb(rs,29), rsb(rs,30), rsb(rs,31)} == 3'b000)) begin
                    r[63-29] = rsb(rs, 29); r[63-30] = rsb(rs, 30); r[63-31] = rsb(rs, 31);
                end
            end
        end
        return r;
    endfunction

    task automatic chk64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] op, input logic l, input logic [63:0] rs,
                        input logic trap, input string tag);
        logic [63:0] prev;
        prev = m_state;
        @(negedge clk);
        op_sel = op; lflag = l; rs_val = rs; trap_req = trap;
        m_state = model(prev, op, l, rs, trap);
        if (trap) m_save = prev;
        m_vld = !trap && (op == 2'b01 || op == 2'b10);
        @(posedge clk);
        @(negedge clk);
        chk64(tag, state_q, m_state);
        chk64(trap ? "R8" : "R11", saved_state, m_save);
        chk64("R10", {63'h0, state_vld}, {63'h0, m_vld});
        if (m_vld) chk64("R7", {63'h0, state_q[60]}, {63'h0, prev[60]});
        if (m_vld && !l && rsb(rs, 49))
            chk64("R3", {61'h0, state_q[15], state_q[5], state_q[4]}, 64'h7);
        op_sel = 2'b00; trap_req = 1'b0;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] rs;
        string       tag;
        rst = 1'b1; op_sel = 2'b00; lflag = 1'b0; rs_val = '0; trap_req = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk64("R1", state_q, RST_V);
        chk64("R1", saved_state, 64'h0);
        chk64("R1", {63'h0, state_vld}, 64'h0);
        m_state = RST_V; m_save = '0; m_vld = 1'b0;

        // R6 guard field sweep: every current x requested 29:31 pair
        for (int c = 0; c < 8; c++) begin
            for (int q = 0; q < 8; q++) begin
                rs = {$urandom, $urandom};
                rs[34:32] = 3'b111;
                step(2'b10, 1'b0, rs, 1'b0, "R5");
                rs[34:32] = c[2:0];
                step(2'b10, 1'b0, rs, 1'b0, "R5");
                rs = {$urandom, $urandom};
                rs[34:32] = q[2:0];
                step(2'b10, 1'b0, rs, 1'b0, "R6");
            end
        end

        // R9 trap with each move select in the same cycle
        for (int k = 0; k < 4; k++)
            step(k[1:0], k[0], {$urandom, $urandom}, 1'b1, "R9");

        // mixed random sweep of select, scope flag and trap
        for (int i = 0; i < 6000; i++) begin
            logic [1:0] op;
            logic       l, tr;
            op = 2'($urandom);
            l  = 1'($urandom);
            tr = ($urandom % 8) == 0;
            rs = {$urandom, $urandom};
            if (tr)                         tag = "R8";
            else if (op == 2'b00 || op == 2'b11) tag = "R11";
            else if (l)                     tag = "R4";
            else if (op == 2'b01)           tag = "R2";
            else                            tag = "R5";
            step(op, l, rs, tr, tag);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule